// File: doc/BRIEF.md
# Three-Stage Forwarding Integer Pipeline

This block is a small in-order integer core. It has three stages. Stage I fetches a 16-bit instruction from the instruction port. Stage A decodes the instruction, reads two registers and computes one of three things: an ALU result, a data address, or a branch target. Stage E writes the result back into the register file or the data memory, or it redirects the program counter. With no hazards the core completes one instruction per clock.

A forwarding path sends the ALU result held in the E-stage buffer to both operand multiplexers of the A stage. A dependent instruction can therefore follow its producer directly and still run at full rate. Two hazards are not handled in hardware and are left to the code:
- The instruction right after a load sees the old value of the loaded register.
- The two instructions after a branch always execute.

Instruction format:
- Bits [15:12] hold the opcode.
- Bits [11:8] hold the destination field `d`. A store uses this field as its data source.
- Bits [7:4] hold the first source field `s`.
- Bits [3:0] hold the second source field `t`. In a load, store or branch, these bits are the 4-bit immediate instead.

The kind of instruction held in the E stage is an enumerated state with five values: `EK_BUBBLE`, `EK_ALU`, `EK_LOAD`, `EK_STORE` and `EK_BRANCH`. On every clock the E stage takes the kind decoded in A. Reset, an invalid A slot and unknown opcodes all move the E stage to `EK_BUBBLE`. A debug port reads any register combinationally.

Top module: `pipe3_core`

## Requirements
- R1: Synchronous reset sets the fetch address to 0 and empties A and E. While reset is held and on the first cycle after it, no data-memory write is issued.
- R2: Without a taken branch, the fetch address rises by exactly 1 on every clock (one instruction per cycle, no stalls).
- R3: The ALU opcodes are 1 ADD, 2 SUB, 3 AND, 4 OR and 5 XOR. Each computes `d = s op t` and writes `d` when the instruction leaves E.
- R4: When the instruction in E is an ALU op whose `d` equals a source field of the instruction in A, that source is taken from the E-stage result buffer. This applies to both operands and to the data of a store.
- R5: Register 0 always reads 0. A write to register 0 is dropped, and a result addressed to register 0 is never forwarded.
- R6: Opcode 6 is a load: `d = mem[s + zext(imm)]`, written only at the end of E. The instruction right after a load reads the register's previous value, and the pipeline does not stall.
- R7: Opcode 7 is a store: `mem[s + zext(imm)] = reg[d]`. The write is issued with `dmem_we` high during the store's E cycle.
- R8: Opcode 8 is a branch taken when `reg[s] == 0`. Its target is the branch's own address plus the sign-extended immediate. The two following instructions always execute, and then fetch continues at the target. An untaken branch falls through.
- R9: Opcode 0 and opcodes 9 to 15 change no register, no memory location and no fetch order.
- R10: `dbg_val` shows the current contents of the register selected by `dbg_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | IADDR_W | Fetch address (the PC) |
| imem_rdata | input | 16 | Instruction at `imem_addr`, combinational |
| dmem_addr | output | DADDR_W | Data address of the instruction in E |
| dmem_wdata | output | DATA_W | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | DATA_W | Load data at `dmem_addr`, combinational |
| dbg_idx | input | 4 | Register selected for debug |
| dbg_val | output | DATA_W | Contents of that register |

## Verification
The key collision happens when E writes a register back in the same cycle that A reads that same register. After an ALU producer, A must get the forwarded value. After a load, A must get the stale value. The test program sets up both cases: dependent ALU chains and stores placed directly behind their producers, and a load followed at once by a consumer. A third case overlaps a taken branch in E with its delay-slot instructions in A, one of which uses a forwarded operand. Each outcome is judged from the store stream, which the scoreboard compares in order, and from the final register contents read through the debug port.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

    localparam int IW    = 16;
    localparam int RIDX_W = 4;
    localparam int NREG  = 1 << RIDX_W;

    localparam logic [3:0] OP_NOP = 4'd0;
    localparam logic [3:0] OP_ADD = 4'd1;
    localparam logic [3:0] OP_SUB = 4'd2;
    localparam logic [3:0] OP_AND = 4'd3;
    localparam logic [3:0] OP_OR  = 4'd4;
    localparam logic [3:0] OP_XOR = 4'd5;
    localparam logic [3:0] OP_LD  = 4'd6;
    localparam logic [3:0] OP_ST  = 4'd7;
    localparam logic [3:0] OP_BZ  = 4'd8;

    typedef enum logic [2:0] {
        EK_BUBBLE,
        EK_ALU,
        EK_LOAD,
        EK_STORE,
        EK_BRANCH
    } ekind_e;

    typedef enum logic [2:0] {
        FN_ADD,
        FN_SUB,
        FN_AND,
        FN_OR,
        FN_XOR
    } alu_fn_e;

endpackage

// File: rtl/pipe3_regfile.sv
module pipe3_regfile
    import pipe3_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NRD    = 3
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [RIDX_W-1:0]    wa,
    input  logic [DATA_W-1:0]    wd,
    input  logic [RIDX_W-1:0]    ra [NRD],
    output logic [DATA_W-1:0]    rd [NRD]
);

    logic [DATA_W-1:0] cells [NREG];

    // register 0 is never written; its read port forces zero
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            cells[wa] <= wd;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rport
        assign rd[g] = (ra[g] == '0) ? '0 : cells[ra[g]];
    end

endmodule

// File: rtl/pipe3_bypass.sv
module pipe3_bypass
    import pipe3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [RIDX_W-1:0] src_idx,
    input  logic [DATA_W-1:0] rf_val,
    input  logic              e_writes_alu,
    input  logic [RIDX_W-1:0] e_dst,
    input  logic [DATA_W-1:0] e_val,
    output logic [DATA_W-1:0] opnd
);

    logic hit;

    always_comb begin
        hit  = e_writes_alu && (e_dst != '0) && (e_dst == src_idx);
        opnd = hit ? e_val : rf_val;
    end

endmodule

// File: rtl/pipe3_alu.sv
module pipe3_alu
    import pipe3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (fn)
            FN_ADD:  y = a + b;
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
    import pipe3_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IADDR_W = 8,
    parameter int DADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [15:0]        imem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dmem_we,
    input  logic [DATA_W-1:0]  dmem_rdata,
    input  logic [3:0]         dbg_idx,
    output logic [DATA_W-1:0]  dbg_val
);

    localparam int NSRC = 2;
    localparam int NRD  = NSRC + 1;
    localparam int IMM_W = 4;

    // ---------------- I stage: program counter ----------------
    logic [IADDR_W-1:0] pc;
    logic               redirect;
    logic [IADDR_W-1:0] e_target;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (redirect) begin
            pc <= e_target;
        end else begin
            pc <= pc + 1'b1;
        end
    end

    assign imem_addr = pc;

    // ---------------- A stage registers ----------------
    logic               a_valid;
    logic [IW-1:0]      a_ir;
    logic [IADDR_W-1:0] a_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            a_ir    <= '0;
            a_pc    <= '0;
        end else begin
            a_valid <= 1'b1;
            a_ir    <= imem_rdata;
            a_pc    <= pc;
        end
    end

    // ---------------- A stage decode ----------------
    logic [3:0]        op;
    logic [RIDX_W-1:0] f_d, f_s, f_t;
    logic [IMM_W-1:0]  imm;
    ekind_e            nx_kind;
    alu_fn_e           fn;
    logic              use_imm;

    always_comb begin
        op      = a_ir[15:12];
        f_d     = a_ir[11:8];
        f_s     = a_ir[7:4];
        f_t     = a_ir[3:0];
        imm     = a_ir[3:0];
        nx_kind = EK_BUBBLE;
        fn      = FN_ADD;
        use_imm = 1'b0;
        if (a_valid) begin
            unique case (op)
                OP_ADD: begin nx_kind = EK_ALU; fn = FN_ADD; end
                OP_SUB: begin nx_kind = EK_ALU; fn = FN_SUB; end
                OP_AND: begin nx_kind = EK_ALU; fn = FN_AND; end
                OP_OR:  begin nx_kind = EK_ALU; fn = FN_OR;  end
                OP_XOR: begin nx_kind = EK_ALU; fn = FN_XOR; end
                OP_LD:  begin nx_kind = EK_LOAD;  use_imm = 1'b1; end
                OP_ST:  begin nx_kind = EK_STORE; use_imm = 1'b1; end
                OP_BZ:  begin nx_kind = EK_BRANCH; end
                default: nx_kind = EK_BUBBLE;
            endcase
        end
    end

    // ---------------- register file and operand bypass ----------------
    ekind_e             e_kind;
    logic [RIDX_W-1:0]  e_rd;
    logic [DATA_W-1:0]  e_res;
    logic [DATA_W-1:0]  e_data;
    logic               e_taken;

    logic               rf_we;
    logic [DATA_W-1:0]  rf_wd;
    logic [RIDX_W-1:0]  rf_ra [NRD];
    logic [DATA_W-1:0]  rf_rd [NRD];
    logic [RIDX_W-1:0]  src_idx [NSRC];
    logic [DATA_W-1:0]  opnd [NSRC];
    logic               e_alu_wr;

    assign src_idx[0] = f_s;
    assign src_idx[1] = (op == OP_ST) ? f_d : f_t;
    assign e_alu_wr   = (e_kind == EK_ALU);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign rf_ra[g] = src_idx[g];
        pipe3_bypass #(.DATA_W(DATA_W)) u_byp (
            .src_idx     (src_idx[g]),
            .rf_val      (rf_rd[g]),
            .e_writes_alu(e_alu_wr),
            .e_dst       (e_rd),
            .e_val       (e_res),
            .opnd        (opnd[g])
        );
    end
    assign rf_ra[NSRC] = dbg_idx;
    assign dbg_val     = rf_rd[NSRC];

    pipe3_regfile #(.DATA_W(DATA_W), .NRD(NRD)) u_rf (
        .clk(clk),
        .we (rf_we),
        .wa (e_rd),
        .wd (rf_wd),
        .ra (rf_ra),
        .rd (rf_rd)
    );

    // ---------------- ALU and branch target ----------------
    logic [DATA_W-1:0]  alu_b;
    logic [DATA_W-1:0]  alu_y;
    logic [IADDR_W-1:0] br_tgt;

    assign alu_b  = use_imm ? {{(DATA_W-IMM_W){1'b0}}, imm} : opnd[1];
    assign br_tgt = a_pc + {{(IADDR_W-IMM_W){imm[IMM_W-1]}}, imm};

    pipe3_alu #(.DATA_W(DATA_W)) u_alu (
        .fn(fn),
        .a (opnd[0]),
        .b (alu_b),
        .y (alu_y)
    );

    // ---------------- E stage state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            e_kind   <= EK_BUBBLE;
            e_rd     <= '0;
            e_res    <= '0;
            e_data   <= '0;
            e_target <= '0;
            e_taken  <= 1'b0;
        end else begin
            e_kind   <= nx_kind;
            e_rd     <= f_d;
            e_res    <= alu_y;
            e_data   <= opnd[1];
            e_target <= br_tgt;
            e_taken  <= (opnd[0] == '0);
        end
    end

    // ---------------- E stage outputs ----------------
    always_comb begin
        rf_we    = 1'b0;
        rf_wd    = e_res;
        dmem_we  = 1'b0;
        redirect = 1'b0;
        unique case (e_kind)
            EK_BUBBLE: ;
            EK_ALU:    rf_we = 1'b1;
            EK_LOAD:   begin rf_we = 1'b1; rf_wd = dmem_rdata; end
            EK_STORE:  dmem_we = 1'b1;
            EK_BRANCH: redirect = e_taken;
            default:   ;
        endcase
    end

    assign dmem_addr  = e_res[DADDR_W-1:0];
    assign dmem_wdata = e_data;

    // ---------------- assertions ----------------
    p_reset_bubble_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && !dmem_we))
        else $error("p_reset_bubble_r1");

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(redirect)) |-> (pc == $past(pc) + 1'b1))
        else $error("p_pc_step_r2");

    p_fwd_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (e_kind == EK_ALU && e_rd != '0 && e_rd == src_idx[0]) |-> (opnd[0] == e_res))
        else $error("p_fwd_hit_r4");

    p_zero_src_r5: assert property (@(posedge clk) disable iff (rst)
        (src_idx[1] == '0) |-> (opnd[1] == '0))
        else $error("p_zero_src_r5");

    p_load_stale_r6: assert property (@(posedge clk) disable iff (rst)
        (e_kind == EK_LOAD && e_rd == src_idx[0]) |-> (opnd[0] == rf_rd[0]))
        else $error("p_load_stale_r6");

    p_branch_go_r8: assert property (@(posedge clk) disable iff (rst)
        (e_kind == EK_BRANCH && e_taken) |=> (pc == $past(e_target)))
        else $error("p_branch_go_r8");

endmodule

// File: tb/sim_pipe3_core.sv
`timescale 1ns/1ps
module sim_pipe3_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [15:0] imem_rdata;
    logic [7:0]  dmem_addr;
    logic [15:0] dmem_wdata;
    logic        dmem_we;
    logic [15:0] dmem_rdata;
    logic [3:0]  dbg_idx = 4'd0;
    logic [15:0] dbg_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    bit wrong_path = 1'b0;

    logic [15:0] prog [256];
    logic [15:0] dm   [256];

    logic [7:0]  exp_a [$];
    logic [15:0] exp_d [$];
    string       exp_r [$];

    always #2.5 clk = ~clk;

    pipe3_core u0 (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_we(dmem_we), .dmem_rdata(dmem_rdata),
        .dbg_idx(dbg_idx), .dbg_val(dbg_val)
    );

    assign imem_rdata = prog[imem_addr];
    assign dmem_rdata = dm[dmem_addr];

    always @(posedge clk) if (!rst && dmem_we) dm[dmem_addr] <= dmem_wdata;

    function automatic logic [15:0] enc(input int op, input int d, input int s, input int t);
        return {op[3:0], d[3:0], s[3:0], t[3:0]};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_store(input int a, input int d, input string req);
        exp_a.push_back(a[7:0]);
        exp_d.push_back(d[15:0]);
        exp_r.push_back(req);
    endtask

    // monitor: compare each issued store with the scoreboard head
    always @(negedge clk) begin
        if (!rst && dmem_we) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R9 unexpected store", int'(dmem_addr), -1);
            end else begin
                automatic logic [7:0]  ea = exp_a.pop_front();
                automatic logic [15:0] ed = exp_d.pop_front();
                automatic string       er = exp_r.pop_front();
                check(dmem_addr == ea, {er, " addr"}, int'(dmem_addr), int'(ea));
                check(dmem_wdata == ed, {er, " data"}, int'(dmem_wdata), int'(ed));
            end
        end
        if (!rst && (imem_addr inside {8'd21, 8'd22, 8'd23, 8'd32})) wrong_path = 1'b1;
    end

    task automatic check_reg(input int idx, input int exp, input string req);
        dbg_idx = idx[3:0];
        #0.5;
        check(dbg_val == exp[15:0], req, int'(dbg_val), exp);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            prog[i] = 16'h0000;
            dm[i]   = 16'h0100 + i[15:0];
        end
        dm[1] = 16'd7;
        dm[2] = 16'd3;
        prog[0]  = enc(6, 1, 0, 1);    // LD r1 <- 7
        prog[1]  = enc(6, 2, 0, 2);    // LD r2 <- 3
        prog[2]  = enc(0, 0, 0, 0);
        prog[3]  = enc(1, 3, 1, 2);    // r3 = 10
        prog[4]  = enc(2, 4, 3, 1);    // r4 = 3 (forwarded r3)
        prog[5]  = enc(7, 4, 0, 8);    // ST r4 -> [8]
        prog[6]  = enc(3, 5, 3, 2);    // r5 = 2
        prog[7]  = enc(4, 6, 5, 1);    // r6 = 7
        prog[8]  = enc(5, 7, 6, 3);    // r7 = 13
        prog[9]  = enc(7, 7, 0, 9);    // ST r7 -> [9]
        prog[10] = enc(1, 0, 1, 1);    // write r0 dropped
        prog[11] = enc(1, 8, 0, 2);    // r8 = 0 + 3
        prog[12] = enc(7, 8, 0, 10);   // ST r8 -> [10]
        prog[13] = enc(6, 1, 0, 2);    // LD r1 <- 3
        prog[14] = enc(1, 10, 1, 0);   // stale r1 = 7
        prog[15] = enc(1, 11, 1, 0);   // new r1 = 3
        prog[16] = enc(7, 10, 0, 11);  // ST r10 -> [11]
        prog[17] = enc(7, 11, 0, 12);  // ST r11 -> [12]
        prog[18] = enc(8, 0, 0, 6);    // BZ r0 -> 24
        prog[19] = enc(1, 12, 2, 2);   // slot 1: r12 = 6
        prog[20] = enc(1, 13, 12, 2);  // slot 2: r13 = 9
        prog[21] = enc(7, 12, 0, 14);  // skipped
        prog[22] = enc(7, 12, 0, 15);  // skipped
        prog[23] = enc(1, 3, 0, 0);    // skipped
        prog[24] = enc(7, 13, 0, 14);  // ST r13 -> [14]
        prog[25] = enc(8, 0, 2, 7);    // BZ r2 not taken
        prog[26] = enc(7, 2, 0, 15);   // ST r2 -> [15]
        prog[27] = enc(15, 3, 1, 1);   // unknown opcode
        prog[28] = enc(7, 3, 0, 7);    // ST r3 -> [7]
        prog[29] = enc(8, 0, 0, 0);    // spin

        // driver: expected store stream
        expect_store(8, 3, "R3 R4 R7 sub fwd");
        expect_store(9, 13, "R3 R4 xor fwd");
        expect_store(10, 3, "R5 r0 not fwd");
        expect_store(11, 7, "R6 load stale");
        expect_store(12, 3, "R6 load after");
        expect_store(14, 9, "R8 slot fwd");
        expect_store(15, 3, "R8 not taken");
        expect_store(7, 10, "R9 unknown op");

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(imem_addr == 8'd0 && !dmem_we, "R1 reset", int'(imem_addr), 0);
        rst = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            check(imem_addr == k[7:0], "R2 fetch step", int'(imem_addr), k);
        end
        repeat (60) @(negedge clk);
        check(exp_a.size() == 0, "R7 stores pending", exp_a.size(), 0);
        check(!wrong_path, "R8 wrong path fetch", int'(wrong_path), 0);
        check_reg(0, 0, "R5 r0");
        check_reg(1, 3, "R6 r1");
        check_reg(2, 3, "R10 r2");
        check_reg(3, 10, "R9 r3");
        check_reg(4, 3, "R4 r4");
        check_reg(5, 2, "R3 r5");
        check_reg(6, 7, "R3 r6");
        check_reg(7, 13, "R3 r7");
        check_reg(8, 3, "R5 r8");
        check_reg(10, 7, "R6 r10");
        check_reg(11, 3, "R6 r11");
        check_reg(12, 6, "R8 r12");
        check_reg(13, 9, "R8 r13");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule